// File: doc/BRIEF.md
# Vertical-Interval Ancillary Line Selector and Packer

This block sits behind a data slicer that recovers ancillary bytes from video lines. It decides, one byte at a time, whether the current line is one that software has enabled, and queues only bytes from enabled lines. A small state machine then turns each queued byte into output words for insertion into the horizontal blanking interval. In half-byte mode each byte becomes two words that can never take the reserved all-zeros or all-ones codes. In straight mode each byte becomes one unchanged 8-bit word.

Line selection uses a 16-bit enable mask that covers odd-field lines 10 to 25, one bit per line. Bytes that arrive on any other line, on a line whose bit is clear, or in the even field are dropped. An end-of-window strobe marks the close of the blanking interval. Any words still waiting at that point are discarded, and a one-cycle overflow pulse reports the loss.

The packer has four states. `ST_IDLE` waits for a queued byte. `ST_HI` sends the upper nibble word. `ST_LO` sends the lower nibble word. `ST_BYTE` sends a byte unchanged. The transitions are:
- `ST_IDLE`→`ST_HI`, or `ST_IDLE`→`ST_BYTE`, when a byte is popped (the byte's stored format picks the state).
- `ST_HI`→`ST_LO`, always.
- `ST_LO`/`ST_BYTE`→`ST_HI`/`ST_BYTE` when another byte is popped back-to-back.
- `ST_LO`/`ST_BYTE`→`ST_IDLE` when the queue is empty.
- Any state→`ST_IDLE` on the window-end flush.

Top module: `anc_line_packer`

## Requirements
- R1: Mask bit i enables line 10+i in the odd field (bit 0 = line 10, bit 15 = line 25). A byte that arrives with `din_valid` high on an enabled line produces output words.
- R2: A byte that arrives in any of the following cases produces no output word and no overflow pulse: `odd_field` is 0, the line is outside 10..25, or the line's mask bit is 0. An all-zero mask selects no line.
- R3: With format bit 0, a byte becomes two words, upper nibble first. Each word is `{2'b01, nibble, 2'b00}`: bit 7 = 0, bit 6 = 1, nibble in bits [5:2], bits [1:0] = 0.
- R4: With format bit 1, a byte becomes one word equal to the byte.
- R5: No half-byte word is 0x00 or 0xFF, including for the input bytes 0x00 and 0xFF.
- R6: A byte accepted at clock edge E, with the packer idle, gives its first word with `dout_valid` high in the cycle after edge E+1. Words of consecutive bytes follow with no gap and in arrival order.
- R7: When `blank_end` is high, the word shown in that cycle still counts. All other pending words are discarded and never appear. `dout_valid` is low in the next cycle. If any word was discarded, `overflow` is high for exactly one cycle, the cycle after `blank_end`.
- R8: `blank_end` raises no overflow if no word is pending: the packer is in `ST_IDLE`, `ST_LO` or `ST_BYTE`, and the queue is empty.
- R9: The format bit is captured with each byte when it arrives. Bytes of different formats that are queued together each keep their own format.
- R10: A byte on an enabled line that arrives in the same cycle as `blank_end` is dropped and counts as discarded, so it raises `overflow`.
- R11: After reset, `dout_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_num | input | 10 | Current video line number |
| odd_field | input | 1 | 1 in the odd field |
| blank_end | input | 1 | One-cycle strobe at the close of the blanking window |
| line_mask | input | 16 | Per-line enable, bit i = line 10+i |
| fmt_straight | input | 1 | 0 = half-byte words, 1 = straight bytes |
| din | input | 8 | Decoded ancillary byte |
| din_valid | input | 1 | `din` holds a byte this cycle |
| dout | output | 8 | Output word |
| dout_valid | output | 1 | `dout` holds a word this cycle |
| overflow | output | 1 | One-cycle pulse: words were discarded at window end |

## Verification
Two events can fall in the same cycle: the window-end flush, and either a word in flight or a new byte arriving. The bench provokes the first by sending a three-byte burst and sliding `blank_end` across every cycle of the drain, in both formats. For each offset it computes how many words must have escaped and whether a loss pulse is due. It provokes the second by raising `din_valid` and `blank_end` together, on an enabled line and on a disabled line. It judges both cases by the exact count and content of the words captured and by the number of overflow cycles.

// File: rtl/anc_pkg.sv
package anc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HI,
        ST_LO,
        ST_BYTE
    } pk_state_t;

    typedef struct packed {
        logic              straight;
        logic [BYTE_W-1:0] data;
    } anc_entry_t;

    // Half-byte framing: 0 1 n n n n 0 0, never all zeros or all ones
    function automatic logic [BYTE_W-1:0] nib_word(input logic [3:0] nib);
        return {2'b01, nib, 2'b00};
    endfunction

endpackage

// File: rtl/anc_line_gate.sv
module anc_line_gate #(
    parameter int LINE_W     = 10,
    parameter int FIRST_LINE = 10,
    parameter int MASK_W     = 16
) (
    input  logic [LINE_W-1:0] line_num,
    input  logic              odd_field,
    input  logic [MASK_W-1:0] line_mask,
    input  logic              din_valid,
    input  logic              blank_end,
    output logic              accept,
    output logic              late_hit
);

    logic [MASK_W-1:0] sel;
    logic              hit;

    for (genvar i = 0; i < MASK_W; i++) begin : g_line
        assign sel[i] = line_mask[i] && (line_num == LINE_W'(FIRST_LINE + i));
    end

    always_comb begin
        hit      = odd_field && (|sel);
        accept   = din_valid && hit && !blank_end;
        late_hit = din_valid && hit && blank_end;
    end

    // R1: a line number can match at most one mask bit
    always_comb begin
        assert_single_line_R1: assert ($onehot0(sel));
    end

endmodule

// File: rtl/anc_entry_fifo.sv
module anc_entry_fifo
    import anc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       wr_en,
    input  anc_entry_t wr_data,
    input  logic       rd_en,
    output anc_entry_t rd_data,
    output logic       empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    anc_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, do_wr, do_rd;

    always_comb begin
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
        rd_data = mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr && !flush)
            mem[wr_ptr] <= wr_data;
    end

    // R6: occupancy never exceeds the storage
    assert_queue_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7: a flush leaves the queue empty
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/anc_word_packer.sv
module anc_word_packer
    import anc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              q_empty,
    input  anc_entry_t        q_data,
    output logic              q_pop,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_valid,
    output logic              pending
);

    pk_state_t         state, nxt;
    logic [BYTE_W-1:0] hold;
    logic              take;

    always_comb begin
        take = !flush && !q_empty && (state != ST_HI);
        nxt  = state;
        unique case (state)
            ST_IDLE: if (take) nxt = q_data.straight ? ST_BYTE : ST_HI;
            ST_HI:   nxt = ST_LO;
            ST_LO,
            ST_BYTE: if (take) nxt = q_data.straight ? ST_BYTE : ST_HI;
                     else      nxt = ST_IDLE;
        endcase
        if (flush)
            nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hold  <= '0;
        end else begin
            state <= nxt;
            if (take)
                hold <= q_data.data;
        end
    end

    always_comb begin
        q_pop      = take;
        pending    = (state == ST_HI);
        dout       = '0;
        dout_valid = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_HI: begin
                dout       = nib_word(hold[7:4]);
                dout_valid = 1'b1;
            end
            ST_LO: begin
                dout       = nib_word(hold[3:0]);
                dout_valid = 1'b1;
            end
            ST_BYTE: begin
                dout       = hold;
                dout_valid = 1'b1;
            end
        endcase
    end

    // R3: the upper nibble word is always followed by the lower one
    assert_hi_then_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI && !flush) |=> (state == ST_LO));

    // R5: half-byte words keep their fixed framing bits
    assert_half_word_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI || state == ST_LO) |->
            (dout[7:6] == 2'b01 && dout[1:0] == 2'b00));

endmodule

// File: rtl/anc_line_packer.sv
module anc_line_packer
    import anc_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int FIRST_LINE = 10,
    parameter int MASK_W     = 16,
    parameter int Q_DEPTH    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_num,
    input  logic              odd_field,
    input  logic              blank_end,
    input  logic [MASK_W-1:0] line_mask,
    input  logic              fmt_straight,
    input  logic [7:0]        din,
    input  logic              din_valid,
    output logic [7:0]        dout,
    output logic              dout_valid,
    output logic              overflow
);

    logic       accept, late_hit;
    logic       q_empty, q_pop, pending;
    anc_entry_t q_in, q_out;
    logic       overflow_q;

    assign q_in = '{straight: fmt_straight, data: din};

    anc_line_gate #(
        .LINE_W    (LINE_W),
        .FIRST_LINE(FIRST_LINE),
        .MASK_W    (MASK_W)
    ) u_gate (
        .line_num (line_num),
        .odd_field(odd_field),
        .line_mask(line_mask),
        .din_valid(din_valid),
        .blank_end(blank_end),
        .accept   (accept),
        .late_hit (late_hit)
    );

    anc_entry_fifo #(
        .DEPTH(Q_DEPTH)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (blank_end),
        .wr_en  (accept),
        .wr_data(q_in),
        .rd_en  (q_pop),
        .rd_data(q_out),
        .empty  (q_empty)
    );

    anc_word_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (blank_end),
        .q_empty   (q_empty),
        .q_data    (q_out),
        .q_pop     (q_pop),
        .dout      (dout),
        .dout_valid(dout_valid),
        .pending   (pending)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            overflow_q <= 1'b0;
        else
            overflow_q <= blank_end && (pending || !q_empty || late_hit);
    end

    assign overflow = overflow_q;

    // R7: a loss pulse only follows a window end
    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(blank_end));

    // R7: nothing is sent in the cycle after the window closes
    assert_window_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blank_end |=> !dout_valid);

    // R2: even-field bytes never enter an empty queue
    assert_even_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!odd_field && q_empty) |=> q_empty);

endmodule

// File: tb/sim_anc_line_packer.sv
module sim_anc_line_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  line_num = '0;
    logic        odd_field = 1'b0;
    logic        blank_end = 1'b0;
    logic [15:0] line_mask = '0;
    logic        fmt_straight = 1'b0;
    logic [7:0]  din = '0;
    logic        din_valid = 1'b0;
    logic [7:0]  dout;
    logic        dout_valid;
    logic        overflow;

    int nvec = 0;
    int nfail = 0;
    int ncap = 0;
    int novf = 0;
    logic [7:0] cap [64];
    bit   done = 1'b0;

    always #4 clk = ~clk;

    anc_line_packer u0 (
        .clk(clk), .rst_n(rst_n), .line_num(line_num), .odd_field(odd_field),
        .blank_end(blank_end), .line_mask(line_mask), .fmt_straight(fmt_straight),
        .din(din), .din_valid(din_valid), .dout(dout), .dout_valid(dout_valid),
        .overflow(overflow)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (dout_valid && ncap < 64) begin
                cap[ncap] = dout;
                ncap++;
            end
            if (overflow) novf++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] hw(input logic [3:0] n);
        return 8'h40 | (8'(n) << 2);
    endfunction

    // expected word k of byte stream in given format
    task automatic chk_byte_words(input logic [7:0] b, input bit straight, input int base, input string req);
        if (straight) begin
            chk(cap[base] == b, req, cap[base], b);
        end else begin
            chk(cap[base] == hw(b[7:4]), req, cap[base], hw(b[7:4]));
            chk(cap[base+1] == hw(b[3:0]), req, cap[base+1], hw(b[3:0]));
            chk(cap[base] != 8'h00 && cap[base] != 8'hFF && cap[base+1] != 8'h00 &&
                cap[base+1] != 8'hFF, "R5", cap[base], 8'h40);
        end
    endtask

    task automatic line_trial(input int line, input int field, input int mm, input int fmt, input logic [7:0] b);
        bit en;
        @(negedge clk);
        ncap = 0; novf = 0;
        line_num = 10'(line); odd_field = field[0]; fmt_straight = fmt[0];
        if (line >= 10 && line <= 25) begin
            if (mm == 0)      line_mask = 16'h1 << (line - 10);
            else if (mm == 1) line_mask = ~(16'h1 << (line - 10));
            else              line_mask = 16'h0;
        end else begin
            line_mask = (mm == 2) ? 16'h0 : 16'hFFFF;
        end
        en = field[0] && line >= 10 && line <= 25 && line_mask[line-10 >= 0 ? (line - 10) % 16 : 0];
        din = b; din_valid = 1'b1;
        @(negedge clk); din_valid = 1'b0;
        repeat (6) @(negedge clk);
        blank_end = 1'b1;
        @(negedge clk); blank_end = 1'b0;
        repeat (2) @(negedge clk);
        if (en) begin
            chk(ncap == (fmt ? 1 : 2), fmt ? "R1 R4 count" : "R1 R3 count", ncap, fmt ? 1 : 2);
            if (ncap == (fmt ? 1 : 2))
                chk_byte_words(b, fmt[0], 0, fmt ? "R4" : "R3");
        end else begin
            chk(ncap == 0, "R2 dropped", ncap, 0);
        end
        chk(novf == 0, "R8 no overflow", novf, 0);
    endtask

    // three-byte burst, window closes in cycle after edge k
    task automatic burst(input int k, input bit straight);
        logic [7:0] b [3];
        int exp_words, tot, wi;
        b[0] = 8'h3C; b[1] = 8'hF0; b[2] = 8'h0F;
        tot = straight ? 3 : 6;
        exp_words = (k < tot) ? k : tot;
        @(negedge clk);
        ncap = 0; novf = 0;
        line_num = 10'd12; odd_field = 1'b1; line_mask = 16'hFFFF;
        fmt_straight = straight;
        for (int j = 0; j < k + 6; j++) begin
            din_valid = (j < 3);
            din = (j < 3) ? b[j] : 8'h00;
            blank_end = (j == k + 1);
            @(negedge clk);
        end
        din_valid = 1'b0; blank_end = 1'b0;
        repeat (8) @(negedge clk);
        chk(ncap == exp_words, "R7 R6 words before close", ncap, exp_words);
        wi = 0;
        for (int i = 0; i < ncap && i < exp_words; i++) begin
            logic [7:0] e;
            if (straight) e = b[i];
            else e = (i % 2 == 0) ? hw(b[i/2][7:4]) : hw(b[i/2][3:0]);
            chk(cap[i] == e, "R6 order", cap[i], e);
            wi++;
        end
        chk(novf == ((k < tot) ? 1 : 0), (k < tot) ? "R7 overflow pulse" : "R8 no overflow",
            novf, (k < tot) ? 1 : 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dout_valid == 1'b0, "R11 reset valid", dout_valid, 0);
        chk(overflow == 1'b0, "R11 reset overflow", overflow, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4 R5: sweep lines, fields, mask shapes, formats
        for (int line = 6; line <= 29; line++)
            for (int field = 0; field < 2; field++)
                for (int mm = 0; mm < 3; mm++)
                    for (int fmt = 0; fmt < 2; fmt++)
                        line_trial(line, field, mm, fmt,
                                   8'((line * 37 + fmt * 91 + mm * 13 + field * 200) & 255));

        // R5: reserved code inputs in both formats
        line_trial(10, 1, 0, 0, 8'h00);
        line_trial(25, 1, 0, 0, 8'hFF);
        line_trial(17, 1, 0, 1, 8'h00);
        line_trial(17, 1, 0, 1, 8'hFF);

        // R6 R7 R8: slide the window end across a burst
        for (int k = 1; k <= 7; k++) burst(k, 1'b0);
        for (int k = 1; k <= 4; k++) burst(k, 1'b1);

        // R9: mixed formats queued back to back
        @(negedge clk);
        ncap = 0; novf = 0;
        line_num = 10'd20; odd_field = 1'b1; line_mask = 16'hFFFF;
        din = 8'hA5; fmt_straight = 1'b0; din_valid = 1'b1;
        @(negedge clk);
        din = 8'h00; fmt_straight = 1'b1;
        @(negedge clk);
        din_valid = 1'b0; fmt_straight = 1'b0;
        repeat (8) @(negedge clk);
        chk(ncap == 3, "R9 mixed count", ncap, 3);
        if (ncap == 3) begin
            chk(cap[0] == hw(4'hA), "R9 hi", cap[0], hw(4'hA));
            chk(cap[1] == hw(4'h5), "R9 lo", cap[1], hw(4'h5));
            chk(cap[2] == 8'h00, "R9 straight", cap[2], 0);
        end

        // R10: byte and window end in the same cycle
        @(negedge clk);
        ncap = 0; novf = 0;
        din = 8'h77; din_valid = 1'b1; blank_end = 1'b1;
        @(negedge clk);
        din_valid = 1'b0; blank_end = 1'b0;
        repeat (6) @(negedge clk);
        chk(ncap == 0, "R10 dropped", ncap, 0);
        chk(novf == 1, "R10 overflow", novf, 1);

        // R10 with the line disabled: no loss reported
        @(negedge clk);
        ncap = 0; novf = 0;
        line_mask = 16'h0;
        din_valid = 1'b1; blank_end = 1'b1;
        @(negedge clk);
        din_valid = 1'b0; blank_end = 1'b0;
        repeat (6) @(negedge clk);
        chk(ncap == 0 && novf == 0, "R10 disabled line", novf, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule